// File: doc/BRIEF.md
# Task-Based Modem Host Command Controller

This block is the host-facing front end of a packet data modem. A microcontroller writes payload bytes into a small data buffer. It then writes a task code into the command register. The block decides whether that code is a data-handling task, and reads it as a receive or a transmit operation according to the modem's current mode. Buffer ownership moves from the host to the modem while the task runs.

In transmit mode the buffered bytes go to a downstream interleave buffer over a ready/valid stream. The stream starts once the transmitter is idle or has room for the whole payload. When the last byte has left, the buffer-free flag and the interrupt flag are both set. An active-low interrupt line follows the interrupt flag, gated by an enable input. In receive mode the decoded task is announced to the receive engine, and the task ends when that engine reports completion.

Top module: `modemHostCtl`

## Requirements
- R1: After reset, bufFree=1, irqFlag=0, errFlag=0, irqN=1, dnValid=0 and taskGo=0.
- R2: The task field is the 4-bit cmdTask. Codes 1 to 5 are data-handling tasks. An accepted task pulses taskGo for one cycle with taskOp={modeTx, cmdTask[2:0]}. Receive codes are 1 search head, 2 read head, 3 read block, 4 search sync and 5 read byte. Transmit codes are 1 head, 2 block, 3 four bytes, 4 single byte and 5 scrambler output.
- R3: A data-handling task written while bufFree=1 is accepted, and bufFree reads 0 from the next cycle.
- R4: In transmit mode, codes 1, 2, 3 and 4 send 7, BLOCK_LEN, 4 and 1 bytes respectively on dnData. The bytes go out in the order they were written, starting with byte 0.
- R5: After acceptance, dnValid stays 0 until dnIdle=1 or dnRoom is at least the payload length.
- R6: While dnValid=1 and dnReady=0, dnValid and dnData hold. After the last byte is accepted, bufFree and irqFlag both become 1.
- R7: irqN is 0 exactly when irqFlag=1 and irqEnable=1. A statusRd pulse clears irqFlag.
- R8: Code 8 is RESET and is accepted in any state. From the next cycle, bufFree=1, dnValid=0, irqFlag=0 and errFlag=0. The write pointer restarts at byte 0.
- R9: Code 0 (no operation) and the reserved codes 6, 7 and 9 to 15 do nothing while bufFree=1. They produce no taskGo, no dnValid and no change to bufFree.
- R10: While bufFree=0, a command write other than RESET and every buffer write are ignored, and each sets errFlag. errFlag stays set until RESET.
- R11: Transmit code 5 clears bufFree for one cycle and then sets bufFree and irqFlag. It never raises dnValid.
- R12: A receive task keeps bufFree=0 until rxDone is pulsed. bufFree and irqFlag become 1 on the second edge after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeTx | input | 1 | 1 = transmit mode, 0 = receive mode |
| irqEnable | input | 1 | Interrupt output enable |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdTask | input | 4 | Task field of the command byte |
| bufWrEn | input | 1 | Data buffer write strobe |
| bufWrData | input | 8 | Data buffer write byte |
| statusRd | input | 1 | Status read strobe, clears the interrupt flag |
| rxDone | input | 1 | Receive engine reports the current task finished |
| dnIdle | input | 1 | Downstream transmitter is idle |
| dnRoom | input | ROOM_W | Free bytes in the interleave buffer |
| dnReady | input | 1 | Interleave buffer accepts a byte |
| dnValid | output | 1 | Byte on dnData is valid |
| dnData | output | 8 | Payload byte to the interleave buffer |
| bufFree | output | 1 | Host owns the data buffer |
| irqFlag | output | 1 | Interrupt status flag |
| errFlag | output | 1 | Sticky busy-access error flag |
| irqN | output | 1 | Active-low interrupt |
| taskGo | output | 1 | One-cycle pulse for an accepted task |
| taskOp | output | 4 | Mode bit and task code of the accepted task |

## Verification
Several properties are checked on every cycle:
- bufFree drops after each acceptance.
- A stalled byte holds while dnReady is low.
- A stream never starts without room or an idle transmitter.
- Every rise of bufFree that is not caused by RESET comes with irqFlag.
- errFlag is sticky.
- No byte is stored while the buffer is busy.

Only the bench scenarios can show the rest. These cover the byte order and length for each transmit code, the mode-dependent taskOp values, the inert codes, and the cancellation of a stalled transfer by RESET. They also cover the interrupt gating through irqEnable and statusRd.

// File: rtl/modemHostPkg.sv
package modemHostPkg;
  localparam logic [3:0] CODE_NULL  = 4'd0;
  localparam logic [3:0] CODE_HEAD  = 4'd1;
  localparam logic [3:0] CODE_BLOCK = 4'd2;
  localparam logic [3:0] CODE_QUAD  = 4'd3;
  localparam logic [3:0] CODE_ONE   = 4'd4;
  localparam logic [3:0] CODE_SCRAM = 4'd5;
  localparam logic [3:0] CODE_RESET = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITROOM,
    ST_SEND,
    ST_RXBUSY,
    ST_FINISH
  } ctlState_t;

  typedef struct packed {
    logic storeByte;
    logic advanceRd;
    logic clearPtrs;
  } bufStrobes_t;
endpackage

// File: rtl/modemHostData.sv
module modemHostData
  import modemHostPkg::*;
#(
  parameter int DEPTH = 18,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  bufStrobes_t      strobes,
  input  logic [7:0]       bufWrData,
  output logic [CNT_W-1:0] rdIdx,
  output logic [7:0]       dnData
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wrPtr;
  logic [CNT_W-1:0] rdPtr;
  logic             wrRoom;

  assign wrRoom = (32'(wrPtr) < 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (strobes.storeByte && wrRoom) mem[wrPtr[IDX_W-1:0]] <= bufWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearPtrs) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.storeByte && wrRoom) wrPtr <= wrPtr + 1'b1;
      if (strobes.advanceRd) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign rdIdx  = rdPtr;
  assign dnData = (32'(rdPtr) < 32'(DEPTH)) ? mem[rdPtr[IDX_W-1:0]] : 8'h00;

  // R4: the control never advances the read pointer past the stored block
  a_r4_rd_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advanceRd |-> (32'(rdPtr) < 32'(DEPTH)));
endmodule

// File: rtl/modemHostCtrl.sv
module modemHostCtrl
  import modemHostPkg::*;
#(
  parameter int BLOCK_LEN = 18,
  parameter int CNT_W     = 5,
  parameter int ROOM_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeTx,
  input  logic              irqEnable,
  input  logic              cmdWrEn,
  input  logic [3:0]        cmdTask,
  input  logic              bufWrEn,
  input  logic              statusRd,
  input  logic              rxDone,
  input  logic              dnIdle,
  input  logic [ROOM_W-1:0] dnRoom,
  input  logic              dnReady,
  input  logic [CNT_W-1:0]  rdIdx,
  output bufStrobes_t       strobes,
  output logic              dnValid,
  output logic              bufFree,
  output logic              irqFlag,
  output logic              errFlag,
  output logic              irqN,
  output logic              taskGo,
  output logic [3:0]        taskOp
);
  ctlState_t        state;
  logic [CNT_W-1:0] lenReg;
  logic             resetCmd, isTask, accept, busyErr, roomOk, lastByte;

  function automatic logic [CNT_W-1:0] taskLen(input logic [3:0] code);
    case (code)
      CODE_HEAD:  taskLen = CNT_W'(7);
      CODE_BLOCK: taskLen = CNT_W'(BLOCK_LEN);
      CODE_QUAD:  taskLen = CNT_W'(4);
      CODE_ONE:   taskLen = CNT_W'(1);
      default:    taskLen = '0;
    endcase
  endfunction

  assign resetCmd = cmdWrEn && (cmdTask == CODE_RESET);
  assign isTask   = (cmdTask >= CODE_HEAD) && (cmdTask <= CODE_SCRAM);
  assign accept   = cmdWrEn && isTask && bufFree;
  assign busyErr  = !bufFree && ((cmdWrEn && !resetCmd) || bufWrEn);
  assign roomOk   = dnIdle || (32'(dnRoom) >= 32'(lenReg));
  assign lastByte = (rdIdx == lenReg - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || resetCmd) begin
      state   <= ST_IDLE;
      bufFree <= 1'b1;
      irqFlag <= 1'b0;
      errFlag <= 1'b0;
      lenReg  <= '0;
      taskGo  <= 1'b0;
      taskOp  <= '0;
    end else begin
      taskGo <= 1'b0;
      if (busyErr) errFlag <= 1'b1;
      if (statusRd) irqFlag <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          bufFree <= 1'b0;
          taskGo  <= 1'b1;
          taskOp  <= {modeTx, cmdTask[2:0]};
          if (!modeTx) state <= ST_RXBUSY;
          else if (cmdTask == CODE_SCRAM) state <= ST_FINISH;
          else begin
            lenReg <= taskLen(cmdTask);
            state  <= ST_WAITROOM;
          end
        end
        ST_WAITROOM: if (roomOk) state <= ST_SEND;
        ST_SEND:     if (dnReady && lastByte) state <= ST_FINISH;
        ST_RXBUSY:   if (rxDone) state <= ST_FINISH;
        ST_FINISH: begin
          bufFree <= 1'b1;
          irqFlag <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dnValid           = (state == ST_SEND);
  assign strobes.storeByte = bufWrEn && bufFree && !resetCmd;
  assign strobes.advanceRd = dnValid && dnReady;
  assign strobes.clearPtrs = resetCmd || (state == ST_FINISH);
  assign irqN              = !(irqFlag && irqEnable);

  // R3: acceptance hands the buffer to the modem on the next cycle
  a_r3_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    accept && !resetCmd |=> !bufFree);
  // R5: a stream only starts with room or an idle transmitter
  a_r5_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITROOM) && !roomOk && !resetCmd |=> !dnValid);
  // R6: a stalled byte stays offered
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    dnValid && !dnReady && !resetCmd |=> dnValid);
  // R6: a completion that is not a RESET always raises the interrupt flag
  a_r6_done_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFree) && !$past(resetCmd) |-> irqFlag);
  // R10: the error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !resetCmd |=> errFlag);
  // R10: nothing is stored while the modem owns the buffer
  a_r10_no_store_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |-> bufFree);
endmodule

// File: rtl/modemHostCtl.sv
module modemHostCtl
  import modemHostPkg::*;
#(
  parameter int BLOCK_LEN = 18,
  parameter int ROOM_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeTx,
  input  logic              irqEnable,
  input  logic              cmdWrEn,
  input  logic [3:0]        cmdTask,
  input  logic              bufWrEn,
  input  logic [7:0]        bufWrData,
  input  logic              statusRd,
  input  logic              rxDone,
  input  logic              dnIdle,
  input  logic [ROOM_W-1:0] dnRoom,
  input  logic              dnReady,
  output logic              dnValid,
  output logic [7:0]        dnData,
  output logic              bufFree,
  output logic              irqFlag,
  output logic              errFlag,
  output logic              irqN,
  output logic              taskGo,
  output logic [3:0]        taskOp
);
  localparam int DEPTH = (BLOCK_LEN > 7) ? BLOCK_LEN : 7;
  localparam int CNT_W = $clog2(DEPTH + 1);

  bufStrobes_t      strobes;
  logic [CNT_W-1:0] rdIdx;

  modemHostCtrl #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W), .ROOM_W(ROOM_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeTx(modeTx), .irqEnable(irqEnable),
    .cmdWrEn(cmdWrEn), .cmdTask(cmdTask), .bufWrEn(bufWrEn),
    .statusRd(statusRd), .rxDone(rxDone), .dnIdle(dnIdle), .dnRoom(dnRoom),
    .dnReady(dnReady), .rdIdx(rdIdx), .strobes(strobes), .dnValid(dnValid),
    .bufFree(bufFree), .irqFlag(irqFlag), .errFlag(errFlag), .irqN(irqN),
    .taskGo(taskGo), .taskOp(taskOp)
  );

  modemHostData #(.DEPTH(DEPTH), .CNT_W(CNT_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bufWrData(bufWrData),
    .rdIdx(rdIdx), .dnData(dnData)
  );

  // R6: the offered byte does not change during a stall
  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    dnValid && !dnReady && !(cmdWrEn && cmdTask == CODE_RESET) |=> $stable(dnData));
endmodule

// File: tb/modemHostCtl_tb_top.sv
module modemHostCtl_tb_top;
  localparam int BLOCK_LEN = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeTx = 1'b1, irqEnable = 1'b0, cmdWrEn = 1'b0, bufWrEn = 1'b0;
  logic statusRd = 1'b0, rxDone = 1'b0, dnIdle = 1'b1, dnReady = 1'b0;
  logic [3:0] cmdTask = '0;
  logic [7:0] bufWrData = '0;
  logic [7:0] dnRoom = '0;
  logic dnValid, bufFree, irqFlag, errFlag, irqN, taskGo;
  logic [7:0] dnData;
  logic [3:0] taskOp;

  int nTests = 0, nFail = 0;
  int readyMode = 1;
  int capN = 0, goCnt = 0;
  logic [7:0] cap [64];
  logic [7:0] expB [64];
  logic [3:0] lastOp = '0;

  always #5 clk = ~clk;

  modemHostCtl #(.BLOCK_LEN(BLOCK_LEN), .ROOM_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .modeTx(modeTx), .irqEnable(irqEnable),
    .cmdWrEn(cmdWrEn), .cmdTask(cmdTask), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData), .statusRd(statusRd), .rxDone(rxDone),
    .dnIdle(dnIdle), .dnRoom(dnRoom), .dnReady(dnReady), .dnValid(dnValid),
    .dnData(dnData), .bufFree(bufFree), .irqFlag(irqFlag), .errFlag(errFlag),
    .irqN(irqN), .taskGo(taskGo), .taskOp(taskOp)
  );

  always @(posedge clk) begin
    #1;
    if (readyMode == 0) dnReady = 1'b0;
    else if (readyMode == 1) dnReady = 1'b1;
    else dnReady = ($urandom % 3) != 0;
  end

  always @(negedge clk) begin
    if (taskGo) begin
      goCnt++;
      lastOp = taskOp;
    end
    if (dnValid && dnReady && capN < 64) begin
      cap[capN] = dnData;
      capN++;
    end
  end

  function automatic int lenOf(input logic [3:0] c);
    case (c)
      4'd1: return 7;
      4'd2: return BLOCK_LEN;
      4'd3: return 4;
      4'd4: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wrBuf(input logic [7:0] b);
    bufWrEn = 1'b1; bufWrData = b;
    tick();
    bufWrEn = 1'b0;
  endtask

  task automatic wrCmd(input logic [3:0] c);
    cmdWrEn = 1'b1; cmdTask = c;
    tick();
    cmdWrEn = 1'b0;
  endtask

  task automatic waitFree();
    for (int g = 0; g < 2000 && !bufFree; g++) tick();
  endtask

  task automatic clearIrq();
    statusRd = 1'b1;
    tick();
    statusRd = 1'b0;
    chk("R7 statusRd clears irqFlag", irqFlag, 0);
    chk("R7 irqN released", irqN, 1);
  endtask

  // transmit run; gated=1 holds the stream back first
  task automatic txRun(input logic [3:0] c, input bit gated);
    int n = lenOf(c);
    int goBefore;
    modeTx = 1'b1;
    for (int i = 0; i < n; i++) begin
      expB[i] = 8'($urandom);
      wrBuf(expB[i]);
    end
    capN = 0;
    goBefore = goCnt;
    if (gated) begin
      dnIdle = 1'b0;
      dnRoom = 8'(n - 1);
    end
    wrCmd(c);
    chk("R3 bufFree cleared on accept", bufFree, 0);
    if (gated) begin
      repeat (6) tick();
      chk("R5 no stream without room", {31'd0, dnValid} | 32'(capN), 0);
      dnRoom = 8'(n);
    end
    waitFree();
    dnIdle = 1'b1;
    chk("R2 taskOp transmit", {28'd0, lastOp}, {28'd0, 1'b1, c[2:0]});
    chk("R2 single taskGo", goCnt - goBefore, 1);
    chk("R4 byte count", capN, n);
    for (int i = 0; i < n; i++) chk("R4 byte order", cap[i], expB[i]);
    chk("R6 irqFlag at completion", irqFlag, 1);
    chk("R7 irqN gating", irqN, !irqEnable);
    clearIrq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int g0;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    chk("R1 bufFree", bufFree, 1);
    chk("R1 irqFlag", irqFlag, 0);
    chk("R1 errFlag", errFlag, 0);
    chk("R1 irqN", irqN, 1);
    chk("R1 dnValid", dnValid, 0);
    rstN = 1'b1;
    tick();

    // R4/R5/R6 directed transmit lengths
    irqEnable = 1'b1;
    txRun(4'd1, 1'b0);
    txRun(4'd2, 1'b1);
    irqEnable = 1'b0;
    txRun(4'd3, 1'b0);
    txRun(4'd4, 1'b1);

    // R11 scrambler output
    capN = 0;
    wrCmd(4'd5);
    chk("R11 bufFree low", bufFree, 0);
    tick();
    chk("R11 bufFree back", bufFree, 1);
    chk("R11 irqFlag", irqFlag, 1);
    chk("R11 no bytes", capN, 0);
    clearIrq();

    // R9 inert codes in both modes
    for (int m = 0; m < 2; m++) begin
      modeTx = m[0];
      foreach (expB[k]) if (k < 5) begin
        logic [3:0] c;
        c = (k == 0) ? 4'd0 : (k == 1) ? 4'd6 : (k == 2) ? 4'd7 : (k == 3) ? 4'd9 : 4'd15;
        g0 = goCnt; capN = 0;
        wrCmd(c);
        tick();
        chk("R9 bufFree unchanged", bufFree, 1);
        chk("R9 no taskGo", goCnt - g0, 0);
        chk("R9 no stream", capN, 0);
        chk("R9 no error", errFlag, 0);
      end
    end

    // R2/R12 receive tasks
    modeTx = 1'b0;
    for (int c = 1; c <= 5; c++) begin
      g0 = goCnt;
      wrCmd(4'(c));
      chk("R3 rx accept", bufFree, 0);
      tick();
      chk("R2 rx taskGo", goCnt - g0, 1);
      chk("R2 rx taskOp", {28'd0, lastOp}, {28'd0, 1'b0, 3'(c)});
      repeat (3) tick();
      chk("R12 waits for rxDone", bufFree, 0);
      if (c == 3) begin
        g0 = goCnt;
        wrCmd(4'd1);
        chk("R10 busy command error", errFlag, 1);
        wrBuf(8'hEE);
        tick();
        chk("R10 busy command ignored", goCnt - g0, 0);
      end
      rxDone = 1'b1;
      tick();
      rxDone = 1'b0;
      tick();
      chk("R12 bufFree after rxDone", bufFree, 1);
      chk("R12 irqFlag after rxDone", irqFlag, 1);
      clearIrq();
    end
    chk("R10 error sticky", errFlag, 1);
    wrCmd(4'd8);
    chk("R8 error cleared", errFlag, 0);

    // R8 RESET during a stalled transfer
    modeTx = 1'b1;
    readyMode = 0;
    for (int i = 0; i < BLOCK_LEN; i++) wrBuf(8'(i + 8'h40));
    wrCmd(4'd2);
    repeat (4) tick();
    chk("R6 stalled stream offered", dnValid, 1);
    chk("R6 stalled first byte", dnData, 8'h40);
    wrCmd(4'd8);
    chk("R8 bufFree", bufFree, 1);
    chk("R8 dnValid", dnValid, 0);
    chk("R8 irqFlag", irqFlag, 0);
    readyMode = 1;
    txRun(4'd4, 1'b0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      readyMode = 1 + ($urandom % 2);
      irqEnable = $urandom % 2;
      txRun(4'(1 + $urandom % 4), ($urandom % 4) == 0);
    end
    readyMode = 1;
    summary();
  end
endmodule